// File: doc/BRIEF.md
# Prioritised Interrupt Arbiter with Pin Sensing

This block gathers interrupt requests from a set of external pins and from on-chip peripheral sources and picks one request to present to the processor. Each source carries a 3-bit priority code in which 0 is the most urgent and 7 switches the source off. The winner is offered on a single request line together with its vector (the source index) and its level. It is offered only when its level is strictly below the current mask level, which the block holds and software may overwrite.

Each external pin has its own sense mode: rising edge, falling edge, either edge, high level or low level. Pins pass through a two-flop synchroniser. In the edge modes a pending bit latches the event and holds it until an acknowledge or an explicit clear. In the level modes the request simply follows the synchronised pin. Peripheral requests are taken as levels and are not synchronised.

When the processor acknowledges an offered request, the block clears that source's pending bit and loads the mask with the source's level. Lower-priority work is then held off until software lowers the mask again.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset every source has priority code 7, every sense mode is rising edge, every pending bit is clear, the mask level is 0 and `irq_o` is low.
- R2: A source whose priority code is 7 never wins arbitration, even while it is requesting.
- R3: In sense mode 0 (rising), 1 (falling) or 2 (both), the selected edge on a pin sets its pending bit. `irq_o` can reflect it on the third rising clock edge after the pin changes, and not earlier. The bit stays set after the pin returns to its old state. An edge of the other polarity sets nothing.
- R4: In sense mode 3 (high) or 4 (low), the request follows the synchronised pin with two clock edges of latency and is not latched.
- R5: Sense codes 5, 6 and 7 produce no request from that pin in any pin state.
- R6: Among the enabled, requesting sources, the one with the numerically lowest priority code wins. External pins are sources 0 to N_EXT-1 and peripheral inputs follow from index N_EXT upward. `irq_level_o` gives the winner's code.
- R7: When two winning candidates have equal codes, the lower source index wins.
- R8: `irq_o` is high only when the winner's code is numerically lower than the mask level. Writing `mask_we_i` loads `mask_wdata_i` into the mask.
- R9: An acknowledge taken while `irq_o` is high clears the winner's pending bit, and loads the mask with the winner's level on the same clock edge. `irq_vec_o` equals the winner's source index.
- R10: A pulse on `clr_we_i` clears the pending bit of pin `clr_sel_i`. A new edge in the same cycle takes precedence.
- R11: An acknowledge while `irq_o` is low changes neither the mask nor any pending bit.
- R12: A configuration write puts `cfg_wdata_i[2:0]` into the priority and `cfg_wdata_i[5:3]` into the sense mode of source `cfg_sel_i`. Peripheral sources ignore the sense field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin_i | input | N_EXT | Raw external interrupt pins |
| per_req_i | input | N_PER | Peripheral request levels |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | IDX_W | Source index to configure |
| cfg_wdata_i | input | 6 | Sense mode [5:3], priority [2:0] |
| clr_we_i | input | 1 | Pending clear strobe |
| clr_sel_i | input | IDX_W | Pin whose pending bit is cleared |
| mask_we_i | input | 1 | Mask write strobe |
| mask_wdata_i | input | 3 | New mask level |
| ack_i | input | 1 | Processor acknowledge |
| irq_o | output | 1 | Request to the processor |
| irq_vec_o | output | VEC_W | Winning source index |
| irq_level_o | output | 3 | Winning priority code |
| mask_o | output | 3 | Current mask level |

## Verification
Pin patterns are driven through every sense mode. In each mode the bench checks both the active transition and the inactive one, and samples one cycle before the expected latency as well as at it. This separates latched from followed requests and catches a sense mode that answers to the wrong polarity. Peripheral sources are then given equal and unequal codes, which separates the lowest-code rule from the lowest-index tie-break. Moving the mask across the winner's level checks the strict comparison. Acknowledges are issued with and without an offered request. The winner that appears after an acknowledge shows whether the right pending bit was cleared.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  typedef logic [2:0] lvl_t;
  localparam lvl_t LVL_OFF = 3'd7;
  localparam logic [2:0] SNS_RISE = 3'd0;
  localparam logic [2:0] SNS_FALL = 3'd1;
  localparam logic [2:0] SNS_BOTH = 3'd2;
  localparam logic [2:0] SNS_HIGH = 3'd3;
  localparam logic [2:0] SNS_LOW  = 3'd4;
endpackage

// File: rtl/irq_pin_sense.sv
module irq_pin_sense
  import irq_prio_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_i,
  input  logic [2:0] mode_i,
  input  logic       clr_i,
  output logic       req_o
);
  logic s1_q, s2_q, s3_q, pend_q, pend_d;
  logic rise, fall, hit;

  always_comb begin
    rise = s2_q & ~s3_q;
    fall = ~s2_q & s3_q;
    case (mode_i)
      SNS_RISE: hit = rise;
      SNS_FALL: hit = fall;
      SNS_BOTH: hit = rise | fall;
      default:  hit = 1'b0;
    endcase
    if (hit)        pend_d = 1'b1;
    else if (clr_i) pend_d = 1'b0;
    else            pend_d = pend_q;
    case (mode_i)
      SNS_RISE, SNS_FALL, SNS_BOTH: req_o = pend_q;
      SNS_HIGH: req_o = s2_q;
      SNS_LOW:  req_o = ~s2_q;
      default:  req_o = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      s3_q   <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      s1_q   <= pin_i;
      s2_q   <= s1_q;
      s3_q   <= s2_q;
      pend_q <= pend_d;
    end
  end

  assert_clear_drops_pending_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !hit) |=> !pend_q);
  assert_pending_only_in_edge_mode_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> ($past(mode_i) <= SNS_BOTH));
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_prio_pkg::*;
#(
  parameter int N     = 19,
  parameter int IDX_W = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         req_i,
  input  lvl_t [N-1:0]         prio_i,
  output logic                 valid_o,
  output logic [IDX_W-1:0]     idx_o,
  output lvl_t                 lvl_o
);
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    lvl_o   = LVL_OFF;
    // scan downward so that with <= the lowest index wins a tie
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i] && (prio_i[i] != LVL_OFF) && (!valid_o || prio_i[i] <= lvl_o)) begin
        valid_o = 1'b1;
        idx_o   = IDX_W'(i);
        lvl_o   = prio_i[i];
      end
    end
  end

  assert_winner_enabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (req_i[idx_o] && prio_i[idx_o] == lvl_o && lvl_o != LVL_OFF));
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int N_EXT = 11,
  parameter int N_PER = 8,
  parameter int VEC_W = 8,
  parameter int IDX_W = $clog2(N_EXT + N_PER)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EXT-1:0] ext_pin_i,
  input  logic [N_PER-1:0] per_req_i,
  input  logic             cfg_we_i,
  input  logic [IDX_W-1:0] cfg_sel_i,
  input  logic [5:0]       cfg_wdata_i,
  input  logic             clr_we_i,
  input  logic [IDX_W-1:0] clr_sel_i,
  input  logic             mask_we_i,
  input  logic [2:0]       mask_wdata_i,
  input  logic             ack_i,
  output logic             irq_o,
  output logic [VEC_W-1:0] irq_vec_o,
  output logic [2:0]       irq_level_o,
  output logic [2:0]       mask_o
);
  localparam int N = N_EXT + N_PER;

  lvl_t [N-1:0]           prio_q, prio_d;
  logic [N_EXT-1:0][2:0]  sense_q, sense_d;
  lvl_t                   mask_q, mask_d;
  logic [N-1:0]           req;
  logic [N_EXT-1:0]       pin_clr;
  logic                   win_valid, ack_take;
  logic [IDX_W-1:0]       win_idx;
  lvl_t                   win_lvl;

  genvar g;
  generate
    for (g = 0; g < N_EXT; g++) begin : g_pin
      assign pin_clr[g] = (clr_we_i && clr_sel_i == IDX_W'(g)) ||
                          (ack_take && win_idx == IDX_W'(g));
      irq_pin_sense u_sense (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (ext_pin_i[g]),
        .mode_i (sense_q[g]),
        .clr_i  (pin_clr[g]),
        .req_o  (req[g])
      );
    end
  endgenerate
  assign req[N-1:N_EXT] = per_req_i;

  irq_arbiter #(.N(N), .IDX_W(IDX_W)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_i   (req),
    .prio_i  (prio_q),
    .valid_o (win_valid),
    .idx_o   (win_idx),
    .lvl_o   (win_lvl)
  );

  always_comb begin
    irq_o       = win_valid && (win_lvl < mask_q);
    ack_take    = ack_i && irq_o;
    irq_vec_o   = VEC_W'(win_idx);
    irq_level_o = win_lvl;
    mask_o      = mask_q;
    prio_d      = prio_q;
    sense_d     = sense_q;
    for (int i = 0; i < N; i++) begin
      if (cfg_we_i && cfg_sel_i == IDX_W'(i)) prio_d[i] = cfg_wdata_i[2:0];
    end
    for (int i = 0; i < N_EXT; i++) begin
      if (cfg_we_i && cfg_sel_i == IDX_W'(i)) sense_d[i] = cfg_wdata_i[5:3];
    end
    if (ack_take)       mask_d = win_lvl;
    else if (mask_we_i) mask_d = mask_wdata_i;
    else                mask_d = mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prio_q  <= {N{LVL_OFF}};
      sense_q <= {N_EXT{SNS_RISE}};
      mask_q  <= '0;
    end else begin
      if (cfg_we_i) begin
        prio_q  <= prio_d;
        sense_q <= sense_d;
      end
      if (ack_take || mask_we_i) mask_q <= mask_d;
    end
  end

  assert_ack_loads_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && irq_o) |=> (mask_o == $past(irq_level_o)));
  assert_idle_ack_keeps_mask_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!(ack_i && irq_o) && !mask_we_i) |=> $stable(mask_o));
  assert_offer_below_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> ($past(mask_we_i) || $past(ack_i) || $past(irq_level_o) < mask_o));
endmodule

// File: tb/irq_prio_ctrl_test.sv
module irq_prio_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int N_EXT = 11;
  localparam int N_PER = 8;
  localparam int IDX_W = 5;

  logic clk = 0, rst_n = 0;
  logic [N_EXT-1:0] ext_pin = '0;
  logic [N_PER-1:0] per_req = '0;
  logic cfg_we = 0, clr_we = 0, mask_we = 0, ack = 0;
  logic [IDX_W-1:0] cfg_sel = '0, clr_sel = '0;
  logic [5:0] cfg_wdata = '0;
  logic [2:0] mask_wdata = '0;
  logic irq;
  logic [7:0] vec;
  logic [2:0] lvl, mask;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_prio_ctrl uut (
    .clk(clk), .rst_n(rst_n), .ext_pin_i(ext_pin), .per_req_i(per_req),
    .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_wdata_i(cfg_wdata),
    .clr_we_i(clr_we), .clr_sel_i(clr_sel), .mask_we_i(mask_we),
    .mask_wdata_i(mask_wdata), .ack_i(ack), .irq_o(irq), .irq_vec_o(vec),
    .irq_level_o(lvl), .mask_o(mask)
  );

  task automatic check(int act, int exp, string tag);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg(int idx, int sense, int prio);
    cfg_sel = IDX_W'(idx); cfg_wdata = {3'(sense), 3'(prio)}; cfg_we = 1;
    cyc(1); cfg_we = 0;
  endtask

  task automatic set_mask(int m);
    mask_wdata = 3'(m); mask_we = 1; cyc(1); mask_we = 0;
  endtask

  task automatic clr(int idx);
    clr_sel = IDX_W'(idx); clr_we = 1; cyc(1); clr_we = 0;
  endtask

  task automatic do_ack();
    ack = 1; cyc(1); ack = 0;
  endtask

  task automatic t_reset();
    check(irq, 0, "R1 irq after reset");
    check(mask, 0, "R1 mask after reset");
    per_req[0] = 1; cyc(1);
    check(irq, 0, "R1 default priority disables");
    per_req[0] = 0;
  endtask

  task automatic t_rising();
    cfg(0, 0, 3);
    ext_pin[0] = 1; cyc(2);
    check(irq, 0, "R3 rising not before third edge");
    cyc(1);
    check(irq, 1, "R3 rising latched");
    check(vec, 0, "R3 rising vector");
    check(lvl, 3, "R3 rising level");
    ext_pin[0] = 0; cyc(4);
    check(irq, 1, "R3 pending held after pin drops");
    clr(0);
    check(irq, 0, "R10 clear drops pending");
    cyc(3);
    check(irq, 0, "R3 falling ignored in rising mode");
  endtask

  task automatic t_falling_both();
    cfg(1, 1, 2);
    ext_pin[1] = 1; cyc(4);
    check(irq, 0, "R3 rise ignored in falling mode");
    ext_pin[1] = 0; cyc(3);
    check(vec, 1, "R3 falling vector");
    check(irq, 1, "R3 falling latched");
    clr(1);
    cfg(2, 2, 2);
    ext_pin[2] = 1; cyc(3);
    check(irq, 1, "R3 both mode rise");
    check(vec, 2, "R3 both mode vector");
    clr(2); check(irq, 0, "R10 clear both mode");
    ext_pin[2] = 0; cyc(3);
    check(irq, 1, "R3 both mode fall");
    clr(2);
  endtask

  task automatic t_level();
    cfg(3, 3, 4);
    ext_pin[3] = 1; cyc(1);
    check(irq, 0, "R4 high not before second edge");
    cyc(1);
    check(irq, 1, "R4 high level follows");
    check(vec, 3, "R4 high vector");
    ext_pin[3] = 0; cyc(2);
    check(irq, 0, "R4 high level not latched");
    cfg(4, 4, 4);
    check(irq, 1, "R4 low level asserts");
    check(vec, 4, "R4 low vector");
    ext_pin[4] = 1; cyc(2);
    check(irq, 0, "R4 low level released");
    cfg(3, 3, 7); cfg(4, 4, 7);
  endtask

  task automatic t_reserved();
    for (int m = 5; m < 8; m++) begin
      cfg(5, m, 1);
      ext_pin[5] = 1; cyc(4);
      check(irq, 0, "R5 reserved sense high pin");
      ext_pin[5] = 0; cyc(4);
      check(irq, 0, "R5 reserved sense low pin");
    end
    cfg(5, 0, 7);
  endtask

  task automatic t_arbitrate();
    per_req[0] = 1; cyc(1);
    check(irq, 0, "R2 disabled source ignored");
    cfg(11, 0, 5);
    check(vec, 11, "R2 enabled source wins");
    cfg(11, 0, 7);
    check(irq, 0, "R2 re-disabled");
    cfg(11, 0, 5);
    per_req[1] = 1; cfg(12, 0, 2);
    check(vec, 12, "R6 lower code wins");
    check(lvl, 2, "R6 winner level");
    per_req[2] = 1; cfg(13, 0, 2);
    check(vec, 12, "R7 tie lower index");
    cfg(12, 0, 3);
    check(vec, 13, "R6 new lowest code");
    set_mask(2);
    check(irq, 0, "R8 level equal to mask blocked");
    set_mask(3);
    check(irq, 1, "R8 level below mask offered");
  endtask

  task automatic t_ack();
    set_mask(7);
    cfg(0, 0, 1);
    ext_pin[0] = 1; cyc(3);
    check(vec, 0, "R9 pin request wins");
    check(lvl, 1, "R9 pin level");
    do_ack();
    check(mask, 1, "R9 mask loaded with level");
    check(irq, 0, "R9 nothing below new mask");
    set_mask(7);
    check(vec, 13, "R9 pending cleared by ack");
    per_req[3] = 1; cfg(14, 3, 1);
    check(vec, 14, "R12 peripheral ignores sense field");
    check(lvl, 1, "R12 priority field");
    set_mask(0);
    do_ack();
    check(mask, 0, "R11 idle ack keeps mask");
    set_mask(7);
    check(vec, 14, "R11 idle ack keeps requests");
  endtask

  initial begin
    cyc(2); rst_n = 1; cyc(1);
    t_reset();
    set_mask(7);
    t_rising();
    t_falling_both();
    t_level();
    t_reserved();
    t_arbitrate();
    t_ack();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule